// File: doc/BRIEF.md
# Channel Address Interleave Remover

This block turns a system physical address into the address seen by one memory channel. A socket-level decoder has already picked the memory controller and the channel. This block compares the address against that controller's eight target-address rules. Each rule supplies a base, a limit, two interleave granularities and two way counts. The selected channel's offset for the matching rule is then subtracted. Finally the socket-level and channel-level interleave are removed, one after the other.

A request is a one-cycle `start` pulse with the address and the selections. The block works through the request and raises `done` for one cycle. When `done` is high, the outputs hold the channel address and the way counts, or `err` reports that no rule covered the address. Power-of-two way counts are handled by shifts. Three-way channel interleave uses a bit-serial divide-by-three, so those requests take about one cycle per address bit longer.

Top module: `chan_ilv_remover`

## Requirements
- R1: After reset, `done` and `err` are 0, and no `done` appears without a preceding accepted `start`.
- R2: A rule i of the selected controller covers the address when base(i) <= addr <= limit(i). Here base is base-register bits [31:12] shifted left by 26. Limit is way-register bits [31:12] shifted left by 26 with the low 26 bits set. Both bounds are inclusive. When several rules cover the address, the lowest index wins.
- R3: When no rule covers the address, `done` comes with `err`=1 and `chan_addr`=0.
- R4: Base-register bits [5:4] give the socket interleave bit, and bits [7:6] give the channel interleave bit. Codes 0, 1, 2 and 3 mean bit 6, 8, 12 and 30.
- R5: `skt_ways` = 1 << way-register bits [11:10]. `chn_ways` = way-register bits [9:8] + 1.
- R6: Before interleave removal, the address has the offset subtracted, modulo 2^ADDR_W. The offset is bits [23:4] of the offset register for the selected channel and matching rule, shifted left by 26.
- R7: Removing one level at bit s with w ways gives ((v >> s) / w) << s, ORed with the low s bits of a low-bits source.
- R8: A three-way channel level divides exactly by 3 and truncates.
- R9: With three channel ways and a socket bit above the channel bit, the channel level is removed first and then the socket level. Each step takes its low bits from the value it is working on.
- R10: In all other cases the socket level is removed first and then the channel level. Both steps take their low bits from the original system address.
- R11: `done` lasts exactly one cycle. A `start` that arrives while a request is in progress is ignored and produces no extra `done`.
- R12: The rule tables are selected by `mc_sel`, and the offset is selected by `ch_sel` (which must be below NCH). Rule i of controller m sits at bits [(m*NENT+i)*32 +: 32]. Offset i of controller m, channel c sits at bits [((m*NCH+c)*NENT+i)*32 +: 32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| sys_addr | input | ADDR_W | System physical address |
| mc_sel | input | MC_W | Controller selected by the socket decoder |
| ch_sel | input | CH_W | Channel selected by the socket decoder |
| base_tbl | input | NMC*NENT*32 | Base registers: base bits, channel and socket granularity codes |
| way_tbl | input | NMC*NENT*32 | Way registers: limit bits, socket way code, channel ways minus one |
| off_tbl | input | NMC*NCH*NENT*32 | Per-channel offset registers |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | No rule covered the address (valid with done) |
| chan_addr | output | ADDR_W | Channel-local address (valid with done) |
| skt_ways | output | 4 | Socket way count |
| chn_ways | output | 3 | Channel way count |

## Verification
A wrong step order or a wrong low-bits source shows up only in the bits below the higher granularity bit. For that reason, addresses with dense low-order bit patterns are checked under both orderings, and the result is visible at the first `done`. A divider that drops or repeats a cycle corrupts the quotient at once. It can also shift the `done` strobe, which then reaches the scoreboard as an extra or missing result. Addresses exactly at a base and at a limit, overlapping rules, and mid-request starts each show up as a wrong way count, a spurious `err` or an extra `done`.

// File: rtl/chan_ilv_remover.sv
module chan_ilv_remover #(
  parameter int ADDR_W = 46,
  parameter int NENT   = 8,
  parameter int NMC    = 2,
  parameter int NCH    = 3,
  localparam int MC_W  = (NMC > 1) ? $clog2(NMC) : 1,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         sys_addr,
  input  logic [MC_W-1:0]           mc_sel,
  input  logic [CH_W-1:0]           ch_sel,
  input  logic [NMC*NENT*32-1:0]    base_tbl,
  input  logic [NMC*NENT*32-1:0]    way_tbl,
  input  logic [NMC*NCH*NENT*32-1:0] off_tbl,
  output logic                      done,
  output logic                      err,
  output logic [ADDR_W-1:0]         chan_addr,
  output logic [3:0]                skt_ways,
  output logic [2:0]                chn_ways
);
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam int GSH   = 26;

  typedef enum logic [1:0] {S_IDLE, S_FIND, S_STEP, S_DIV} st_t;
  st_t st;

  logic [ADDR_W-1:0] addr_q, ca, dv, q;
  logic [MC_W-1:0]   mc_q;
  logic [CH_W-1:0]   ch_q;
  logic [4:0]        sbit, cbit;
  logic [1:0]        sw_code, cw_code, rem;
  logic              chfirst, stp;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [4:0] gran(input logic [1:0] c);
    case (c)
      2'd0: gran = 5'd6;
      2'd1: gran = 5'd8;
      2'd2: gran = 5'd12;
      default: gran = 5'd30;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] field26(input logic [19:0] f);
    field26 = ADDR_W'(f) << GSH;
  endfunction

  function automatic logic [ADDR_W-1:0] put_back(input logic [ADDR_W-1:0] v,
      input logic [4:0] s, input logic [ADDR_W-1:0] low);
    logic [ADDR_W-1:0] m;
    m = (ADDR_W'(1) << s) - ADDR_W'(1);
    put_back = (v << s) | (low & m);
  endfunction

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      logic [31:0] b, w;
      b = base_tbl[(int'(mc_q) * NENT + i) * 32 +: 32];
      w = way_tbl[(int'(mc_q) * NENT + i) * 32 +: 32];
      if (field26(b[31:12]) <= addr_q &&
          addr_q <= (field26(w[31:12]) | ADDR_W'((1 << GSH) - 1))) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  logic [31:0] hb, hw, ho;
  assign hb = base_tbl[(int'(mc_q) * NENT + int'(hit_idx)) * 32 +: 32];
  assign hw = way_tbl[(int'(mc_q) * NENT + int'(hit_idx)) * 32 +: 32];
  assign ho = off_tbl[((int'(mc_q) * NCH + int'(ch_q)) * NENT + int'(hit_idx)) * 32 +: 32];

  logic              use_chn, is_div;
  logic [4:0]        s_cur;
  logic [1:0]        k_cur;
  logic [ADDR_W-1:0] low_src, step_val;
  assign use_chn  = stp ? !chfirst : chfirst;
  assign s_cur    = use_chn ? cbit : sbit;
  assign k_cur    = use_chn ? ((cw_code == 2'd3) ? 2'd2 : (cw_code == 2'd1) ? 2'd1 : 2'd0) : sw_code;
  assign is_div   = use_chn && cw_code == 2'd2;
  assign low_src  = chfirst ? ca : addr_q;
  assign step_val = put_back((ca >> s_cur) >> k_cur, s_cur, low_src);

  logic [2:0]        t;
  logic              qbit;
  logic [ADDR_W-1:0] qn;
  assign t    = {rem, dv[ADDR_W-1]};
  assign qbit = t >= 3'd3;
  assign qn   = {q[ADDR_W-2:0], qbit};

  assign skt_ways = 4'd1 << sw_code;
  assign chn_ways = {1'b0, cw_code} + 3'd1;
  assign chan_addr = ca;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; err <= 1'b0;
      addr_q <= '0; mc_q <= '0; ch_q <= '0; ca <= '0; dv <= '0; q <= '0;
      sbit <= '0; cbit <= '0; sw_code <= '0; cw_code <= '0; rem <= '0;
      chfirst <= 1'b0; stp <= 1'b0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= sys_addr; mc_q <= mc_sel; ch_q <= ch_sel; st <= S_FIND;
        end
        S_FIND: begin
          if (!hit) begin
            err <= 1'b1; ca <= '0; sw_code <= '0; cw_code <= '0;
            done <= 1'b1; st <= S_IDLE;
          end else begin
            err <= 1'b0;
            sbit <= gran(hb[5:4]);
            cbit <= gran(hb[7:6]);
            sw_code <= hw[11:10];
            cw_code <= hw[9:8];
            chfirst <= hw[9:8] == 2'd2 && gran(hb[5:4]) > gran(hb[7:6]);
            ca <= addr_q - field26(ho[23:4]);
            stp <= 1'b0;
            st <= S_STEP;
          end
        end
        S_STEP: begin
          if (is_div) begin
            dv <= ca >> s_cur; q <= '0; rem <= '0;
            cnt <= CNT_W'(ADDR_W - 1); st <= S_DIV;
          end else begin
            ca <= step_val;
            stp <= 1'b1;
            if (stp) begin done <= 1'b1; st <= S_IDLE; end
          end
        end
        S_DIV: begin
          rem <= qbit ? 2'(t - 3'd3) : t[1:0];
          q <= qn;
          dv <= dv << 1;
          cnt <= cnt - CNT_W'(1);
          if (cnt == '0) begin
            ca <= put_back(qn, s_cur, low_src);
            stp <= 1'b1;
            if (stp) begin done <= 1'b1; st <= S_IDLE; end
            else st <= S_STEP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R5
  ways_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> $onehot(skt_ways) && chn_ways >= 3'd1 && chn_ways <= 3'd4);
  // R3
  err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done && chan_addr == '0);
  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && start |=> st == S_FIND && !done);
  // R8
  rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DIV |-> rem != 2'd3);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == S_IDLE);
endmodule

// File: tb/chan_ilv_remover_tb.sv
module chan_ilv_remover_tb;
  localparam int AW = 46, NENT = 8, NMC = 2, NCH = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start;
  logic [AW-1:0] sys_addr;
  logic [0:0] mc_sel;
  logic [1:0] ch_sel;
  logic [NMC*NENT*32-1:0] base_tbl, way_tbl;
  logic [NMC*NCH*NENT*32-1:0] off_tbl;
  logic done, err;
  logic [AW-1:0] chan_addr;
  logic [3:0] skt_ways;
  logic [2:0] chn_ways;

  logic [31:0] bt [NMC][NENT];
  logic [31:0] wt [NMC][NENT];
  logic [31:0] ot [NMC][NCH][NENT];

  always_comb begin
    for (int m = 0; m < NMC; m++)
      for (int i = 0; i < NENT; i++) begin
        base_tbl[(m*NENT+i)*32 +: 32] = bt[m][i];
        way_tbl[(m*NENT+i)*32 +: 32] = wt[m][i];
        for (int c = 0; c < NCH; c++)
          off_tbl[((m*NCH+c)*NENT+i)*32 +: 32] = ot[m][c][i];
      end
  end

  chan_ilv_remover u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sys_addr(sys_addr),
    .mc_sel(mc_sel), .ch_sel(ch_sel), .base_tbl(base_tbl), .way_tbl(way_tbl),
    .off_tbl(off_tbl), .done(done), .err(err), .chan_addr(chan_addr),
    .skt_ways(skt_ways), .chn_ways(chn_ways));

  typedef struct {
    logic [63:0] a;
    bit e;
    int sw;
    int cw;
    string tag;
  } item_t;
  item_t sb[$];

  int checks = 0, errors = 0, done_cnt = 0, cyc = 0;
  logic [63:0] MSK = (64'd1 << AW) - 1;

  function automatic int grn(input logic [1:0] c);
    case (c) 2'd0: return 6; 2'd1: return 8; 2'd2: return 12; default: return 30; endcase
  endfunction

  function automatic logic [63:0] strip(input logic [63:0] v, input int s, input int w,
                                        input logic [63:0] low);
    return (((((v >> s) / w) << s) | (low & ((64'd1 << s) - 1))) & MSK);
  endfunction

  function automatic item_t model(input logic [63:0] a, input int m, input int c, input string tag);
    item_t r;
    int hit = -1;
    r.tag = tag; r.e = 1; r.a = 0; r.sw = 1; r.cw = 1;
    for (int i = NENT - 1; i >= 0; i--) begin
      logic [63:0] lo, hi;
      lo = 64'(bt[m][i][31:12]) << 26;
      hi = (64'(wt[m][i][31:12]) << 26) | 64'h3FF_FFFF;
      if (lo <= a && a <= hi) hit = i;
    end
    if (hit >= 0) begin
      int sb_, cb_, sw, cw;
      logic [63:0] ca;
      sb_ = grn(bt[m][hit][5:4]);
      cb_ = grn(bt[m][hit][7:6]);
      sw = 1 << wt[m][hit][11:10];
      cw = int'(wt[m][hit][9:8]) + 1;
      ca = (a - (64'(ot[m][c][hit][23:4]) << 26)) & MSK;
      if (cw == 3 && sb_ > cb_) begin
        ca = strip(ca, cb_, cw, ca);
        ca = strip(ca, sb_, sw, ca);
      end else begin
        ca = strip(ca, sb_, sw, a);
        ca = strip(ca, cb_, cw, a);
      end
      r.e = 0; r.a = ca; r.sw = sw; r.cw = cw;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n && done) begin
      done_cnt++;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11: unexpected done, actual done=1 expected done=0");
      end else begin
        item_t x;
        x = sb.pop_front();
        if (err !== x.e || (!x.e && (64'(chan_addr) !== x.a || int'(skt_ways) != x.sw ||
            int'(chn_ways) != x.cw)) || (x.e && chan_addr !== '0)) begin
          errors++;
          $display("FAIL %s: actual err=%0b addr=%h sw=%0d cw=%0d expected err=%0b addr=%h sw=%0d cw=%0d",
                   x.tag, err, chan_addr, skt_ways, chn_ways, x.e, x.a, x.sw, x.cw);
        end
      end
    end
  end

  task automatic run(input logic [63:0] a, input int m, input int c, input string tag);
    int target;
    sb.push_back(model(a, m, c, tag));
    target = done_cnt + 1;
    @(negedge clk);
    sys_addr = AW'(a); mc_sel = 1'(m); ch_sel = 2'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt < target) @(negedge clk);
  endtask

  function automatic logic [31:0] mkb(input int base, input int cg, input int sg);
    return {20'(base), 4'd0, 2'(cg), 2'(sg), 4'd0};
  endfunction
  function automatic logic [31:0] mkw(input int lim, input int swc, input int cwm1);
    return {20'(lim), 2'(swc), 2'(cwm1), 8'd0};
  endfunction

  initial begin
    for (int m = 0; m < NMC; m++)
      for (int i = 0; i < NENT; i++) begin
        bt[m][i] = mkb(20'hFFFFF, 0, 0);
        wt[m][i] = mkw(0, 0, 0);
        for (int c = 0; c < NCH; c++) ot[m][c][i] = {8'd0, 20'(c), 4'd0};
      end
    bt[0][0] = mkb(0, 1, 0);   wt[0][0] = mkw(3, 1, 2);
    bt[0][1] = mkb(4, 0, 2);   wt[0][1] = mkw(7, 2, 2);
    bt[0][2] = mkb(8, 2, 1);   wt[0][2] = mkw(11, 0, 1);
    bt[0][3] = mkb(12, 1, 3);  wt[0][3] = mkw(15, 3, 3);
    bt[0][4] = mkb(0, 0, 0);   wt[0][4] = mkw(20, 0, 0);
    bt[1][0] = mkb(0, 1, 2);   wt[1][0] = mkw(20'hFFFFF, 2, 2);

    rst_n = 1'b0; start = 1'b0; sys_addr = '0; mc_sel = '0; ch_sel = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (done !== 1'b0 || err !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual done=%0b err=%0b expected done=0 err=0", done, err);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual done=%0b expected done=0 without start", done);
    end

    run(64'h0ABC_DEF5, 0, 0, "R10 R8 R2 socket-then-channel div3, overlap lowest wins");
    run(64'h0F00_1234, 0, 1, "R6 R10 offset subtract");
    run(64'h1234_5678, 0, 2, "R9 R8 channel-first div3");
    run(64'h1FFF_FFFF, 0, 0, "R9 R2 limit of rule1");
    run(64'h2A5A_5A5A, 0, 0, "R7 R4 two-way channel");
    run(64'h3C3C_3C3C, 0, 1, "R5 R4 eight socket four channel ways");
    run(64'h4400_0001, 0, 0, "R7 single way rule4");
    run(64'h0FFF_FFFF, 0, 2, "R2 limit of rule0");
    run(64'h1000_0000, 0, 1, "R2 base of rule1");
    run(64'h5400_0000, 0, 0, "R3 no match above limits");
    run(64'h3FFF_FFFF_FFFF, 0, 2, "R3 top address no match");
    run(64'h0ABC_DEF5, 1, 0, "R12 controller select");
    run(64'h1234_ABCD_EF01, 1, 2, "R12 R9 wide address channel-first");

    begin
      int target;
      sb.push_back(model(64'h0123_4567, 0, 0, "R11 first request"));
      target = done_cnt + 1;
      @(negedge clk);
      sys_addr = AW'(64'h0123_4567); mc_sel = 1'b0; ch_sel = 2'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      sys_addr = AW'(64'h5555_0000); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt < target) @(negedge clk);
      repeat (80) @(negedge clk);
      checks++;
      if (done_cnt != target) begin
        errors++;
        $display("FAIL R11: actual dones=%0d expected dones=%0d", done_cnt, target);
      end
    end

    run(64'h0000_0000, 0, 0, "R10 zero address");
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11: actual pending=%0d expected pending=0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule